// File: doc/BRIEF.md
# Byte-Access Serial Register Slave

This block is a two-wire serial bus slave that gives a host byte-wide access to two control registers of a clock generator. It samples the bus clock and data lines with the system clock and recognises start, repeated start and stop conditions. A transaction addresses the slave with a 7-bit address and a write bit. The host then sends a command byte whose top bit must be set and whose low seven bits name a register offset. The host then either sends one data byte to store or issues a repeated start with the read bit and receives one byte.

Register 0 holds the frequency-select code. Its four select bits normally show the strap inputs. Setting an override-enable bit lets software write its own code, which then drives the `fs_sel` output instead of the straps. Register 0 also shows two interface-mode straps. Register 1 holds the spread-spectrum controls and three clock-control bits, and shows a multiplier strap in its lowest bit.

Top module: `smb_byte_regs`

## Requirements
- R1: After reset `sda_oe` is 0, the override enable is 0, and register 1 bits 7:1 are 0111111.
- R2: The slave acknowledges an address byte only if its upper seven bits equal `DEV_ADDR`. On a mismatch it does not acknowledge, ignores every later byte and leaves all registers unchanged until the next start.
- R3: A command byte with bit 7 = 1 is acknowledged and its bits 6:0 become the offset. A command byte with bit 7 = 0 is not acknowledged, and the data byte that follows is neither acknowledged nor stored.
- R4: After an accepted command, one data byte is acknowledged and stored at the offset. Any further byte in the same transaction is not acknowledged and not stored.
- R5: After an accepted command, a repeated start followed by the address with read bit 1 is acknowledged. The slave then shifts out the addressed register MSB first and releases the line after the eighth bit.
- R6: Register 0 reads as {0, FS[2:0], enable, strap_mem_mode, FS[3], strap_cpu_mode}. FS is the effective select code, which is also driven on `fs_sel`.
- R7: While the enable is 0, writes to FS are ignored, and both register 0 and `fs_sel` follow `strap_fs`. Enable (bit 3) is always writable.
- R8: While the enable is already 1, a write to register 0 stores data bits 6:4 as FS[2:0] and data bit 1 as FS[3]. The stored code drives `fs_sel`, whatever the straps do.
- R9: Register 1 bits 7:1 are writable and drive `spread_center` (bit 7), `spread_en` (bit 6), `spread_bw` (bits 5:4) and `clk_ctl` (bits 3:1). Bit 0 reads `strap_mult`.
- R10: Offsets 2 to 127 read as 0x00, and writes to them change nothing.
- R11: A stop at any point ends the transaction and releases SDA. A data byte cut short by a stop is not stored.
- R12: `sda_oe` changes only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line |
| sda_in | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap_fs | input | 4 | Frequency-select straps FS[3:0] |
| strap_cpu_mode | input | 1 | CPU interface-mode strap |
| strap_mem_mode | input | 1 | Memory interface-mode strap |
| strap_mult | input | 1 | Multiplier-select strap |
| fs_sel | output | 4 | Effective frequency-select code |
| spread_center | output | 1 | 1 = center spread, 0 = down spread |
| spread_en | output | 1 | Spread modulation enable |
| spread_bw | output | 2 | Spread bandwidth select |
| clk_ctl | output | 3 | Register 1 bits 3:1 |

## Verification
The bench writes FS bits while the enable is 0 and expects nothing to stick. A design that gated writes on the incoming enable bit, instead of the stored one, would take the code on the very write that turns the override on. It moves the straps after enabling, so a design that still mirrored the straps would let `fs_sel` drift. It sends a second data byte, a command byte with bit 7 clear, a wrong address and a byte cut short by a stop. Each of these would corrupt register 1 in a design that stored bytes too eagerly. It also reads an unimplemented offset, which would return aliased data if offsets were decoded on too few bits.

// File: rtl/smb_byte_regs.sv
module smb_byte_regs #(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  input  logic [3:0] strap_fs,
  input  logic       strap_cpu_mode,
  input  logic       strap_mem_mode,
  input  logic       strap_mult,
  output logic [3:0] fs_sel,
  output logic       spread_center,
  output logic       spread_en,
  output logic [1:0] spread_bw,
  output logic [2:0] clk_ctl
);
  typedef enum logic [2:0] {IDLE, ADDR, ACK, CMD, WDATA, RDATA, WAIT} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d, scl_s, sda_s;
  logic       start_det, stop_det, scl_rise, scl_fall;
  st_t        state, nxt, after;
  logic [3:0] cnt;
  logic [7:0] sh, rd_byte;
  logic [6:0] offs;
  logic       cmd_ok, byte_ok, wr_commit;
  logic       sw_en;
  logic [3:0] sw_fs;
  logic [6:0] r1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_d  <= scl_sy[1];
      sda_d  <= sda_sy[1];
    end

  assign scl_s     = scl_sy[1];
  assign sda_s     = sda_sy[1];
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;

  assign fs_sel  = sw_en ? sw_fs : strap_fs;
  assign rd_byte = (offs == 7'd0) ? {1'b0, fs_sel[2:0], sw_en, strap_mem_mode, fs_sel[3], strap_cpu_mode} :
                   (offs == 7'd1) ? {r1, strap_mult} : 8'h00;

  always_comb begin
    byte_ok = 1'b0;
    after   = WAIT;
    case (state)
      ADDR:  begin byte_ok = (sh[7:1] == DEV_ADDR) && (sh[0] == cmd_ok); after = cmd_ok ? RDATA : CMD; end
      CMD:   begin byte_ok = sh[7]; after = WDATA; end
      WDATA: begin byte_ok = 1'b1; after = WAIT; end
      default: ;
    endcase
  end

  assign wr_commit = (state == WDATA) && scl_fall && (cnt == 4'd8);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= IDLE; nxt <= IDLE; cnt <= '0; sh <= '0; offs <= '0;
      cmd_ok <= 1'b0; sda_oe <= 1'b0;
    end else if (stop_det) begin
      state <= IDLE; sda_oe <= 1'b0; cmd_ok <= 1'b0;
    end else if (start_det) begin
      state  <= ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
      cmd_ok <= (state == WDATA) && (cnt <= 4'd1);
    end else begin
      case (state)
        ADDR, CMD, WDATA: begin
          if (scl_rise && cnt != 4'd8) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            cnt <= '0;
            nxt <= after;
            if (state == CMD) offs <= sh[6:0];
            if (byte_ok) begin
              state  <= ACK;
              sda_oe <= 1'b1;
            end else begin
              state <= WAIT;
            end
          end
        end
        ACK: if (scl_fall) begin
          state <= nxt;
          cnt   <= '0;
          if (nxt == RDATA) begin
            sh     <= rd_byte;
            sda_oe <= ~rd_byte[7];
          end else begin
            sda_oe <= 1'b0;
          end
        end
        RDATA: if (scl_fall) begin
          if (cnt == 4'd7) begin
            state  <= WAIT;
            sda_oe <= 1'b0;
          end else begin
            cnt    <= cnt + 4'd1;
            sh     <= {sh[6:0], 1'b0};
            sda_oe <= ~sh[6];
          end
        end
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sw_en <= 1'b0;
      sw_fs <= '0;
      r1    <= 7'b0111111;
    end else begin
      if (!sw_en) sw_fs <= strap_fs;
      if (wr_commit) begin
        if (offs == 7'd0) begin
          sw_en <= sh[3];
          if (sw_en) sw_fs <= {sh[1], sh[6:4]};
        end else if (offs == 7'd1) begin
          r1 <= sh[7:1];
        end
      end
    end

  assign spread_center = r1[6];
  assign spread_en     = r1[5];
  assign spread_bw     = r1[4:3];
  assign clk_ctl       = r1[2:0];
endmodule

module smb_byte_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_oe,
  input logic       stop_det,
  input logic       wr_commit,
  input logic       sw_en,
  input logic [3:0] sw_fs,
  input logic [6:0] r1
);
  assert_sda_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));
  assert_stop_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
  assert_reg1_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> $stable(r1));
  assert_fs_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && !wr_commit) |=> $stable(sw_fs));
endmodule

bind smb_byte_regs smb_byte_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .stop_det(stop_det),
  .wr_commit(wr_commit), .sw_en(sw_en), .sw_fs(sw_fs), .r1(r1)
);

// File: tb/tb_smb_byte_regs.sv
module tb_smb_byte_regs;
  localparam logic [6:0] A = 7'h69;
  localparam int Q = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [3:0] st_fs = 4'b0110;
  logic st_cpu = 1'b1, st_mem = 1'b0, st_mult = 1'b1;
  logic sda_oe, sp_c, sp_e;
  logic [3:0] fs_sel;
  logic [1:0] sp_bw;
  logic [2:0] cc;
  wire sda_bus = sda_m & ~sda_oe;

  int tests = 0, fails = 0;
  bit cmp_en = 0, done = 0;
  logic m_en = 0;
  logic [3:0] m_sw = 0;
  logic [6:0] m_r1 = 7'b0111111;
  logic prev_oe = 0;

  always #5 clk = ~clk;

  smb_byte_regs #(.DEV_ADDR(A)) dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus), .sda_oe(sda_oe),
    .strap_fs(st_fs), .strap_cpu_mode(st_cpu), .strap_mem_mode(st_mem), .strap_mult(st_mult),
    .fs_sel(fs_sel), .spread_center(sp_c), .spread_en(sp_e), .spread_bw(sp_bw), .clk_ctl(cc));

  function automatic logic [3:0] m_fs();
    return m_en ? m_sw : st_fs;
  endfunction
  function automatic logic [7:0] exp_reg(input logic [6:0] o);
    logic [3:0] f = m_fs();
    if (o == 0) return {1'b0, f[2:0], m_en, st_mem, f[3], st_cpu};
    if (o == 1) return {m_r1, st_mult};
    return 8'h00;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) if (!m_en) m_sw <= st_fs;

  always @(negedge clk) if (rst_n && cmp_en) begin
    chk(fs_sel == m_fs(), "R7/R8 fs_sel", fs_sel, m_fs());
    chk({sp_c, sp_e, sp_bw, cc} == m_r1, "R9 reg1 outputs", {sp_c, sp_e, sp_bw, cc}, m_r1);
  end

  always @(negedge clk) begin
    if (rst_n && sda_oe != prev_oe) chk(scl_m == 1'b0, "R12 sda change with scl high", scl_m, 0);
    prev_oe <= sda_oe;
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic b_start(); sda_m = 1; scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq(); endtask
  task automatic b_rstart(); sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq(); endtask
  task automatic b_stop(); sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq(); wq(); endtask
  task automatic wbit(input logic b); sda_m = b; wq(); scl_m = 1; wq(); wq(); scl_m = 0; wq(); endtask
  task automatic rbit(output logic b); sda_m = 1; wq(); scl_m = 1; wq(); b = sda_bus; wq(); scl_m = 0; wq(); endtask
  task automatic sbyte(input logic [7:0] v, output bit ack);
    logic x;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(x);
    ack = !x;
  endtask
  task automatic rbyte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) rbit(v[i]);
  endtask

  task automatic xwrite(input logic [6:0] ad, input logic [7:0] cmd, input logic [7:0] d,
                        output bit a0, output bit a1, output bit a2);
    cmp_en = 0;
    b_start(); sbyte({ad, 1'b0}, a0); sbyte(cmd, a1); sbyte(d, a2); b_stop();
  endtask
  task automatic mwrite(input logic [7:0] cmd, input logic [7:0] d);
    if (cmd[7] && cmd[6:0] == 0) begin
      if (m_en) m_sw = {d[1], d[6:4]};
      m_en = d[3];
    end else if (cmd[7] && cmd[6:0] == 1) m_r1 = d[7:1];
    cmp_en = 1;
  endtask
  task automatic wr_ok(input logic [7:0] cmd, input logic [7:0] d, input string tag);
    bit a0, a1, a2;
    xwrite(A, cmd, d, a0, a1, a2);
    chk(a0 && a1 && a2, tag, {a0, a1, a2}, 3'b111);
    mwrite(cmd, d);
  endtask
  task automatic rd_chk(input logic [6:0] o, input string tag);
    bit a0, a1, a2;
    logic [7:0] d;
    logic x;
    cmp_en = 0;
    b_start(); sbyte({A, 1'b0}, a0); sbyte({1'b1, o}, a1);
    b_rstart(); sbyte({A, 1'b1}, a2); rbyte(d); rbit(x); b_stop();
    chk(a0 && a1 && a2, "R2/R3/R5 read acks", {a0, a1, a2}, 3'b111);
    chk(d == exp_reg(o), tag, d, exp_reg(o));
    cmp_en = 1;
  endtask
  task automatic set_straps(input logic [3:0] f);
    @(posedge clk); #1 st_fs = f;
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit a0, a1, a2;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(sda_oe == 0, "R1 sda_oe reset", sda_oe, 0);
    chk({sp_c, sp_e, sp_bw, cc} == 7'b0111111, "R1 reg1 reset", {sp_c, sp_e, sp_bw, cc}, 7'b0111111);
    chk(fs_sel == st_fs, "R1 fs_sel follows straps at reset", fs_sel, st_fs);
    cmp_en = 1;

    rd_chk(0, "R6 reg0 after reset");
    rd_chk(1, "R9 reg1 after reset");
    wr_ok(8'h81, 8'h35, "R4 write acks reg1");
    rd_chk(1, "R9 reg1 readback");

    cmp_en = 0;
    xwrite(7'h2A, 8'h81, 8'hC0, a0, a1, a2);
    chk({a0, a1, a2} == 3'b000, "R2 mismatch no acks", {a0, a1, a2}, 0);
    cmp_en = 1;
    rd_chk(1, "R2 reg1 unchanged after mismatch");

    cmp_en = 0;
    xwrite(A, 8'h01, 8'hAA, a0, a1, a2);
    chk({a0, a1, a2} == 3'b100, "R3 cmd bit7 clear nacked", {a0, a1, a2}, 3'b100);
    cmp_en = 1;
    rd_chk(1, "R3 reg1 unchanged");

    wr_ok(8'h80, 8'h72, "R7 write acks reg0");
    rd_chk(0, "R7 fs ignored while disabled");
    set_straps(4'b1010);
    rd_chk(0, "R7 reg0 follows new straps");
    chk(fs_sel == 4'b1010, "R7 fs_sel follows straps", fs_sel, 4'b1010);

    wr_ok(8'h80, 8'h08, "R8 enable write acks");
    rd_chk(0, "R8 enable set, code kept");
    wr_ok(8'h80, 8'h5A, "R8 code write acks");
    chk(fs_sel == 4'hD, "R8 fs_sel from software", fs_sel, 4'hD);
    set_straps(4'b0011);
    chk(fs_sel == 4'hD, "R8 fs_sel ignores straps", fs_sel, 4'hD);
    rd_chk(0, "R8 reg0 software code");
    wr_ok(8'h80, 8'h00, "R7 disable write acks");
    chk(fs_sel == 4'b0011, "R7 fs_sel back to straps", fs_sel, 4'b0011);

    wr_ok(8'h85, 8'hFF, "R10 unimplemented write acks");
    rd_chk(7'h05, "R10 unimplemented reads 0");
    rd_chk(7'h7F, "R10 top offset reads 0");
    rd_chk(0, "R10 reg0 unchanged");
    rd_chk(1, "R10 reg1 unchanged");

    cmp_en = 0;
    b_start(); sbyte({A, 1'b0}, a0); sbyte(8'h81, a1); sbyte(8'h11, a2);
    chk(a0 && a1 && a2, "R4 first data acked", {a0, a1, a2}, 3'b111);
    sbyte(8'h22, a2); b_stop();
    chk(!a2, "R4 second data nacked", a2, 0);
    mwrite(8'h81, 8'h11);
    rd_chk(1, "R4 only first byte stored");

    cmp_en = 0;
    b_start(); sbyte({A, 1'b0}, a0); sbyte(8'h81, a1);
    for (int i = 0; i < 4; i++) wbit(1'b1);
    b_stop();
    chk(sda_oe == 0, "R11 released after stop", sda_oe, 0);
    cmp_en = 1;
    rd_chk(1, "R11 partial byte not stored");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule